// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches a bank of general-purpose input pins and turns their activity into a single interrupt request. Every pin has its own three configuration bits: one picks level or edge sensing, one picks single-edge or any-edge triggering, and one picks the active polarity, which is the high or low level in level mode and the rising or falling edge in single-edge mode. A detected event sets a sticky per-pin status bit. An enable mask selects which status bits may drive the shared interrupt output.

Software reaches the configuration and status through a small word-addressed register bus. Reads are combinational. Writes take effect at the clock edge. Status bits are cleared by writing ones to a clear location. The block receives the already synchronized pin levels and the per-pin direction vector from the neighbouring data port. It detects edges by comparing each pin with the sample it registered on the previous clock.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the level-select, any-edge, polarity, enable and status registers all read 0, and `irq_o` is low.
- R2: Register words sit at byte offsets `0x00` level-select, `0x04` any-edge, `0x08` polarity, `0x0C` enable, `0x10` raw status (read-only), `0x14` masked status (read-only) and `0x18` clear (write-only, reads 0). Bit i of each register belongs to pin i. Any other address reads 0 and ignores writes, including addresses whose bits above the 3-bit word index are non-zero. Writes to the two status words have no effect.
- R3: A pin in edge mode with any-edge 0 and polarity 1 sets its status bit on a 0-to-1 change between the previous and the current sample, and not on a 1-to-0 change.
- R4: A pin in edge mode with any-edge 0 and polarity 0 sets its status bit on a 1-to-0 change only.
- R5: A pin in edge mode with any-edge 1 sets its status bit on every change, whatever its polarity bit holds.
- R6: A pin in level mode sets its status bit on every clock where its level equals its polarity bit, whatever its direction bit holds. A clear therefore does not remove that bit while the level holds.
- R7: A pin whose direction bit is 1 (output) produces no edge events.
- R8: Masked status equals raw status AND enable. `irq_o` is high exactly when masked status is non-zero.
- R9: A write to the clear word clears each status bit written as 1 and leaves the other bits unchanged.
- R10: When a clear and a new event hit the same bit in the same cycle, the bit ends up set.
- R11: A status bit updates at the clock edge that follows the input change. An edge-mode pin held at a steady level raises no further event after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPIN | Synchronized pin levels |
| dir_i | input | NPIN | Pin direction, 1 = output |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Byte address of the register word |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Each pin in turn is taken through all eight combinations of level, any-edge and polarity, under all four transitions between a start level and an end level. The full status vector is compared, so this sweep separates the rising, falling, any-edge and level behaviours from one another and also exposes any event that leaks onto a neighbouring pin. A fixed status pattern is held while the enable register runs through all 256 values, which checks the masked status and the OR that drives the interrupt. Directed cases then cover output-direction pins, a partial clear, a clear that meets an event in the same cycle, steady levels in edge mode, and writes to unmapped or read-only addresses.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        RG_LVL  = 3'd0,
        RG_ANY  = 3'd1,
        RG_POL  = 3'd2,
        RG_EN   = 3'd3,
        RG_RAW  = 3'd4,
        RG_MSKD = 3'd5,
        RG_CLR  = 3'd6,
        RG_NONE = 3'd7
    } reg_idx_e;

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  reg_idx_e        idx_i,
    input  logic [NPIN-1:0] wdata_i,
    output logic [NPIN-1:0] lvl_o,
    output logic [NPIN-1:0] any_o,
    output logic [NPIN-1:0] pol_o,
    output logic [NPIN-1:0] en_o
);

    typedef struct packed {
        logic [NPIN-1:0] lvl;
        logic [NPIN-1:0] any;
        logic [NPIN-1:0] pol;
        logic [NPIN-1:0] en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            case (idx_i)
                RG_LVL:  cfg_d.lvl = wdata_i;
                RG_ANY:  cfg_d.any = wdata_i;
                RG_POL:  cfg_d.pol = wdata_i;
                RG_EN:   cfg_d.en  = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign lvl_o = cfg_q.lvl;
    assign any_o = cfg_q.any;
    assign pol_o = cfg_q.pol;
    assign en_o  = cfg_q.en;

endmodule

// File: rtl/gpio_irq_event.sv
module gpio_irq_event #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] dir_i,
    input  logic [NPIN-1:0] lvl_i,
    input  logic [NPIN-1:0] any_i,
    input  logic [NPIN-1:0] pol_i,
    output logic [NPIN-1:0] evt_o
);

    logic [NPIN-1:0] prev_d, prev_q;

    always_comb prev_d = pin_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic at_pol;
        logic moved;
        assign at_pol   = ~(pin_i[i] ^ pol_i[i]);
        assign moved    = (pin_i[i] ^ prev_q[i]) & ~dir_i[i];
        assign evt_o[i] = lvl_i[i] ? at_pol : (moved & (any_i[i] | at_pol));
    end

endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] evt_i,
    input  logic [NPIN-1:0] clr_i,
    input  logic [NPIN-1:0] en_i,
    output logic [NPIN-1:0] raw_o,
    output logic [NPIN-1:0] mskd_o,
    output logic            irq_o
);

    logic [NPIN-1:0] raw_d, raw_q;

    always_comb begin
        raw_d = (raw_q & ~clr_i) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    assign raw_o  = raw_q;
    assign mskd_o = raw_q & en_i;
    assign irq_o  = |mskd_o;

    // a status bit may only fall after a clear request
    p_fall_needs_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(raw_q) & ~raw_q)) |-> (|$past(clr_i)));

    // an event always leaves its bit set, even against a clear
    p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int DW   = 32,
    parameter int AW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] dir_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    output logic            irq_o
);

    localparam int WORD_W = AW - 2;

    logic [WORD_W-1:0] word;
    logic              in_map;
    reg_idx_e          idx;
    logic [NPIN-1:0]   lvl, any, pol, en, evt, raw, mskd, clr;

    assign word   = addr_i[AW-1:2];
    assign in_map = (word >> IDX_W) == '0;
    assign idx    = reg_idx_e'(word[IDX_W-1:0]);
    assign clr    = (wr_en_i && in_map && idx == RG_CLR) ? wdata_i[NPIN-1:0] : '0;

    gpio_irq_cfg #(.NPIN(NPIN)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_en_i && in_map),
        .idx_i   (idx),
        .wdata_i (wdata_i[NPIN-1:0]),
        .lvl_o   (lvl),
        .any_o   (any),
        .pol_o   (pol),
        .en_o    (en)
    );

    gpio_irq_event #(.NPIN(NPIN)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .dir_i (dir_i),
        .lvl_i (lvl),
        .any_i (any),
        .pol_i (pol),
        .evt_o (evt)
    );

    gpio_irq_stat #(.NPIN(NPIN)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .clr_i  (clr),
        .en_i   (en),
        .raw_o  (raw),
        .mskd_o (mskd),
        .irq_o  (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        if (in_map) begin
            case (idx)
                RG_LVL:  rdata_o[NPIN-1:0] = lvl;
                RG_ANY:  rdata_o[NPIN-1:0] = any;
                RG_POL:  rdata_o[NPIN-1:0] = pol;
                RG_EN:   rdata_o[NPIN-1:0] = en;
                RG_RAW:  rdata_o[NPIN-1:0] = raw;
                RG_MSKD: rdata_o[NPIN-1:0] = mskd;
                default: rdata_o = '0;
            endcase
        end
    end

    logic [NPIN-1:0] lvl_hit;
    assign lvl_hit = lvl & ~(pin_i ^ pol);

    // output pins in edge mode never raise a status bit
    p_out_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & ~$past(raw) & $past(dir_i & ~lvl)) == '0));

    // a held active level is present in status one edge later
    p_level_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & $past(lvl_hit)) == $past(lvl_hit)));

endmodule

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;

    localparam int NPIN = 8;
    localparam int DW   = 32;
    localparam int AW   = 6;

    localparam logic [AW-1:0] A_LVL  = 6'h00;
    localparam logic [AW-1:0] A_ANY  = 6'h04;
    localparam logic [AW-1:0] A_POL  = 6'h08;
    localparam logic [AW-1:0] A_EN   = 6'h0C;
    localparam logic [AW-1:0] A_RAW  = 6'h10;
    localparam logic [AW-1:0] A_MSKD = 6'h14;
    localparam logic [AW-1:0] A_CLR  = 6'h18;
    localparam logic [AW-1:0] A_HOLE = 6'h1C;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIN-1:0] pin = '0;
    logic [NPIN-1:0] dir = '0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.NPIN(NPIN), .DW(DW), .AW(AW)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin),
        .dir_i   (dir),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        logic [NPIN-1:0] pat;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        for (int k = 0; k < 8; k++) begin
            rd(AW'(k * 4), v);
            chk("R1 reset read", v, '0);
        end
        chk("R1 irq at reset", {31'b0, irq}, '0);

        // R3 R4 R5 R6 R11: per-pin sweep over config and transitions
        for (int p = 0; p < NPIN; p++) begin
            for (int c = 0; c < 8; c++) begin
                for (int s = 0; s < 4; s++) begin
                    logic lb, ab, pb, v0, v1, e;
                    string tag;
                    lb = c[0]; ab = c[1]; pb = c[2];
                    v0 = s[0]; v1 = s[1];
                    wr(A_LVL, DW'(lb) << p);
                    wr(A_ANY, DW'(ab) << p);
                    wr(A_POL, DW'(pb) << p);
                    pin = NPIN'(v0) << p;
                    idle(2);
                    wr(A_CLR, DW'(8'hFF));
                    idle(2);
                    pin = NPIN'(v1) << p;
                    idle(2);
                    if (lb) e = (v0 == pb) || (v1 == pb);
                    else    e = (v0 != v1) && (ab || (v1 == pb));
                    tag = lb ? "R6 level" : ab ? "R5 any edge" : pb ? "R3 rising" : "R4 falling";
                    rd(A_RAW, v);
                    chk(tag, v, DW'(e) << p);
                end
            end
        end

        // R6: build a sticky pattern through level mode
        pat = 8'hA5;
        wr(A_ANY, '0);
        wr(A_POL, '0);
        pin = ~pat;
        wr(A_LVL, DW'(8'hFF));
        idle(1);
        wr(A_LVL, '0);
        idle(2);
        rd(A_RAW, v);
        chk("R6 pattern held", v, DW'(pat));

        // R8: enable sweep over all values
        for (int m = 0; m < 256; m++) begin
            wr(A_EN, DW'(m));
            rd(A_MSKD, v);
            chk("R8 masked", v, DW'(pat & m[7:0]));
            chk("R8 irq", {31'b0, irq}, {31'b0, |(pat & m[7:0])});
        end

        // R9: partial clear
        wr(A_CLR, DW'(8'h0F));
        rd(A_RAW, v);
        chk("R9 partial clear", v, DW'(8'hA0));
        wr(A_CLR, DW'(8'hFF));
        rd(A_RAW, v);
        chk("R9 full clear", v, '0);
        chk("R8 irq low after clear", {31'b0, irq}, '0);

        // R7: output pins ignore edges
        dir = '1;
        wr(A_ANY, DW'(8'hFF));
        pin = ~pin; idle(2);
        pin = ~pin; idle(2);
        rd(A_RAW, v);
        chk("R7 output edges", v, '0);
        // R6: level mode still applies to output pins
        wr(A_POL, DW'(pin));
        wr(A_LVL, DW'(8'hFF));
        idle(1);
        rd(A_RAW, v);
        chk("R6 level on outputs", v, DW'(8'hFF));
        wr(A_LVL, '0);
        dir = '0;
        wr(A_ANY, '0);
        wr(A_POL, DW'(8'h01));
        pin = '0;
        idle(2);
        wr(A_CLR, DW'(8'hFF));
        rd(A_RAW, v);
        chk("R9 clear before collision test", v, '0);

        // R10: clear and rising event in the same cycle
        @(negedge clk);
        addr = A_CLR; wdata = DW'(8'h01); wr_en = 1'b1; pin = 8'h01;
        @(negedge clk);
        wr_en = 1'b0;
        rd(A_RAW, v);
        chk("R10 event beats clear", v, DW'(8'h01));

        // R11: steady level in edge mode, no re-trigger
        wr(A_CLR, DW'(8'h01));
        idle(3);
        rd(A_RAW, v);
        chk("R11 steady no event", v, '0);
        // R11: timing, status follows one edge after the change
        @(negedge clk);
        pin = 8'h00;
        @(negedge clk);
        pin = 8'h01;
        #1;
        v = rdata;
        chk("R11 not before edge", v, '0);
        @(negedge clk);
        rd(A_RAW, v);
        chk("R11 after edge", v, DW'(8'h01));
        wr(A_CLR, DW'(8'hFF));

        // R2: map, read-only and unmapped addresses
        wr(A_ANY, DW'(8'h5A));
        rd(A_ANY, v);
        chk("R2 readback", v, DW'(8'h5A));
        wr(6'h24, DW'(8'hFF));
        rd(A_ANY, v);
        chk("R2 high address ignored", v, DW'(8'h5A));
        rd(6'h24, v);
        chk("R2 high address reads 0", v, '0);
        rd(A_HOLE, v);
        chk("R2 hole reads 0", v, '0);
        rd(A_CLR, v);
        chk("R2 clear reads 0", v, '0);
        wr(A_RAW, DW'(8'hFF));
        wr(A_MSKD, DW'(8'hFF));
        rd(A_RAW, v);
        chk("R2 status write ignored", v, '0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule